// File: doc/BRIEF.md
# I2C Master Counted-Transfer Sequencer

This block sits between a register front end and a bit-level I2C bus engine. It runs a whole combined transfer on its own from one command word. The word describes up to two counted transfers, each with a byte count and a direction. An internal address of one to three bytes may be sent in front of them. After a `go` pulse the sequencer walks through the transfer one byte at a time, handing each step to the bus engine as a request: START, repeated START, a byte write, a byte read with its acknowledge bit, or STOP. It waits for the engine's completion strobe before it issues the next step. Software never writes a STOP: the sequencer issues it as soon as the count of the last active area is used up.

Read bytes come out on `rx_data` with a `rx_valid` strobe. Write bytes are pulled from `tx_data` with a `tx_pop` strobe. A `done` strobe ends every accepted or rejected command. A counted mode can be switched on and off with one-shot inputs. While it is off, the block uses the legacy direction input and the first area's count only.

Top module: `i2c_autostop_seq`

## Requirements
- R1: The command word holds area 0 in bits [8:0] and area 1 in bits [24:16]. In each area, bits [7:0] are the byte count and the next bit up is the direction (1 = read). A transfer begins with a START whose byte is {slave_addr, direction}. The engine op codes are START=1, RSTART=2, WRITE=3, READ=4, STOP=5.
- R2: Every byte moved in a data phase lowers the active area's count by one. When the final area's count reaches zero, a STOP is issued without any software action, and `done` pulses for one cycle after the engine completes it.
- R3: If area 1 has a count of zero, it is unused and the STOP follows area 0. If its count is nonzero, area 0 is followed by a repeated START carrying area 1's direction, with no STOP between the two areas.
- R4: While counted mode is on, `legacy_rd` has no effect. While it is off, only area 0's count is used, its direction comes from `legacy_rd`, and area 1 is ignored.
- R5: A `mode_on` pulse enables counted mode and a `mode_off` pulse disables it. When both pulse together, off wins. The mode is off after reset.
- R6: With `iaddr_len` of 1 to 3, the START carries the write bit and is followed by that many bytes of `iaddr`, highest-numbered byte first. A read area 0 then gets a repeated START with the read bit. A write area 0 continues without one.
- R7: A `go` with area 0 count zero is rejected: `done` pulses in the next cycle and no engine request is made.
- R8: Each read byte is acknowledged (`eng_ack`=1) except the last byte of the final area, which gets `eng_ack`=0.
- R9: A slave NACK on an address or write byte ends the transfer. The next step is a STOP, the remaining bytes are dropped, and `nack_err` is set until the next accepted `go`.
- R10: Each read byte appears on `rx_data` with a one-cycle `rx_valid`. Each write data byte is taken from `tx_data` in the cycle of a one-cycle `tx_pop`. No strobe is active after reset.
- R11: A `go` while `busy` is ignored, and the running transfer keeps its latched command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_on | input | 1 | One-shot enable for counted mode |
| mode_off | input | 1 | One-shot disable for counted mode |
| legacy_rd | input | 1 | Direction used while counted mode is off |
| go | input | 1 | Start a command |
| slave_addr | input | ADDR_W | 7-bit slave address |
| iaddr_len | input | IA_W | Number of internal address bytes (0 to 3) |
| iaddr | input | 8*IADDR_BYTES | Internal address bytes |
| cmd_word | input | 2*AREA_STRIDE | Two count/direction areas |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished or rejected |
| nack_err | output | 1 | Slave refused an address or write byte |
| eng_req | output | 1 | Request pulse to the bus engine |
| eng_op | output | 3 | Requested step code |
| eng_wdata | output | 8 | Address or data byte for the step |
| eng_ack | output | 1 | Master acknowledge for a read step |
| eng_done | input | 1 | Engine finished the step |
| eng_nack | input | 1 | Slave NACK, valid with eng_done |
| eng_rdata | input | 8 | Byte read, valid with eng_done |
| tx_data | input | 8 | Next write data byte |
| tx_pop | output | 1 | Write data byte taken |
| rx_valid | output | 1 | Read byte available |
| rx_data | output | 8 | Read byte |

## Verification
A count that is wrong, or an area that is chosen wrongly, shows at the engine port as a step list that is too long or too short, or as a repeated START or STOP in the wrong place. This is visible by the step after the first wrong byte, so the bench logs every engine request and compares the whole list with a model. A wrong acknowledge choice shows on `eng_ack` at the final read. A wrong error path shows as a data step after a refused byte, or as `nack_err` left clear after `done`. Random commands mix counts, directions, address prefixes, modes and NACK positions. Directed cases cover rejection, the mode clash and a `go` that arrives while busy.

// File: rtl/i2c_aseq_pkg.sv
package i2c_aseq_pkg;
   localparam int BYTE_W  = 8;
   localparam int N_AREAS = 2;

   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_START  = 3'd1,
      OP_RSTART = 3'd2,
      OP_WRITE  = 3'd3,
      OP_READ   = 3'd4,
      OP_STOP   = 3'd5
   } eng_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_IADDR,
      ST_DATA,
      ST_STOP
   } seq_st_e;
endpackage

// File: rtl/aseq_mode_reg.sv
module aseq_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic set_pulse,
   input  logic clr_pulse,
   output logic alt_mode
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         alt_mode <= 1'b0;
      else if (clr_pulse) alt_mode <= 1'b0;
      else if (set_pulse) alt_mode <= 1'b1;
   end

   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> !alt_mode); // R5
   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (set_pulse && !clr_pulse) |=> alt_mode); // R5
endmodule

// File: rtl/aseq_cmd_decode.sv
module aseq_cmd_decode
   import i2c_aseq_pkg::*;
#(
   parameter int LEN_W       = 8,
   parameter int AREA_STRIDE = 16
) (
   input  logic                           alt_mode,
   input  logic                           legacy_rd,
   input  logic [N_AREAS*AREA_STRIDE-1:0] cmd_word,
   output logic [LEN_W-1:0]               len_first,
   output logic                           dir_first,
   output logic [LEN_W-1:0]               len_second,
   output logic                           dir_second,
   output logic                           has_second,
   output logic                           reject
);
   logic [LEN_W-1:0] f_len [N_AREAS];
   logic             f_dir [N_AREAS];
   logic             unused_word;

   generate
      if (LEN_W + 1 > AREA_STRIDE) begin : g_bad_stride
         $error("area stride too small for count plus direction");
      end
      for (genvar a = 0; a < N_AREAS; a++) begin : g_area
         assign f_len[a] = cmd_word[a*AREA_STRIDE +: LEN_W];
         assign f_dir[a] = cmd_word[a*AREA_STRIDE + LEN_W];
      end
   endgenerate

   assign unused_word = ^cmd_word;

   always_comb begin
      len_first  = f_len[0];
      dir_first  = alt_mode ? f_dir[0] : legacy_rd;
      len_second = f_len[1];
      dir_second = f_dir[1];
      has_second = alt_mode && (f_len[1] != '0);
      reject     = (f_len[0] == '0);
   end
endmodule

// File: rtl/aseq_byte_cnt.sv
module aseq_byte_cnt #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             dec,
   output logic             last
);
   logic [LEN_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (dec)  cnt <= cnt - LEN_W'(1);
   end

   assign last = (cnt == LEN_W'(1));

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |-> (cnt != '0)); // R2
endmodule

// File: rtl/i2c_autostop_seq.sv
module i2c_autostop_seq
   import i2c_aseq_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int LEN_W       = 8,
   parameter int AREA_STRIDE = 16,
   parameter int IADDR_BYTES = 3,
   localparam int IA_W       = $clog2(IADDR_BYTES + 1),
   localparam int IA_BITS    = IADDR_BYTES * BYTE_W,
   localparam int CMD_W      = N_AREAS * AREA_STRIDE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_on,
   input  logic               mode_off,
   input  logic               legacy_rd,
   input  logic               go,
   input  logic [ADDR_W-1:0]  slave_addr,
   input  logic [IA_W-1:0]    iaddr_len,
   input  logic [IA_BITS-1:0] iaddr,
   input  logic [CMD_W-1:0]   cmd_word,
   output logic               busy,
   output logic               done,
   output logic               nack_err,
   output logic               eng_req,
   output logic [2:0]         eng_op,
   output logic [7:0]         eng_wdata,
   output logic               eng_ack,
   input  logic               eng_done,
   input  logic               eng_nack,
   input  logic [7:0]         eng_rdata,
   input  logic [7:0]         tx_data,
   output logic               tx_pop,
   output logic               rx_valid,
   output logic [7:0]         rx_data
);
   generate
      if (ADDR_W + 1 != BYTE_W) begin : g_bad_addr
         $error("address plus direction must fill one byte");
      end
      if (IADDR_BYTES < 1) begin : g_bad_ia
         $error("internal address needs at least one byte slot");
      end
   endgenerate

   logic             alt_mode;
   logic [LEN_W-1:0] dec_len0, dec_len1;
   logic             dec_dir0, dec_dir1, dec_has2, dec_reject;

   aseq_mode_reg u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_pulse (mode_on),
      .clr_pulse (mode_off),
      .alt_mode  (alt_mode)
   );

   aseq_cmd_decode #(.LEN_W(LEN_W), .AREA_STRIDE(AREA_STRIDE)) u_dec (
      .alt_mode   (alt_mode),
      .legacy_rd  (legacy_rd),
      .cmd_word   (cmd_word),
      .len_first  (dec_len0),
      .dir_first  (dec_dir0),
      .len_second (dec_len1),
      .dir_second (dec_dir1),
      .has_second (dec_has2),
      .reject     (dec_reject)
   );

   seq_st_e          st;
   eng_op_e          op_q;
   logic             wait_q, rstart_q, area_idx, cur_dir;
   logic             r_dir1, r_has2;
   logic [LEN_W-1:0] r_len1;
   logic [ADDR_W-1:0] r_addr;
   logic [IA_BITS-1:0] r_iaddr;
   logic [IA_W-1:0]  iaddr_left;
   logic [7:0]       ia_byte;
   logic             cnt_load, cnt_dec, cnt_last;
   logic [LEN_W-1:0] cnt_val;
   logic             step_end, wr_refused, final_area;

   assign busy       = (st != ST_IDLE);
   assign eng_op     = op_q;
   assign step_end   = wait_q && eng_done;
   assign wr_refused = step_end && eng_nack && !cur_dir;
   assign final_area = area_idx || !r_has2;

   always_comb begin
      ia_byte = '0;
      for (int k = 0; k < IADDR_BYTES; k++) begin
         if (iaddr_left == IA_W'(k + 1)) ia_byte = r_iaddr[k*BYTE_W +: BYTE_W];
      end
   end

   always_comb begin
      cnt_dec  = (st == ST_DATA) && step_end && !wr_refused;
      cnt_load = 1'b0;
      cnt_val  = r_len1;
      if (st == ST_IDLE && go && !dec_reject) begin
         cnt_load = 1'b1;
         cnt_val  = dec_len0;
      end else if (cnt_dec && cnt_last && !area_idx && r_has2) begin
         cnt_load = 1'b1;
      end
   end

   aseq_byte_cnt #(.LEN_W(LEN_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_load),
      .load_val (cnt_val),
      .dec      (cnt_dec),
      .last     (cnt_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;  op_q <= OP_NONE;
         wait_q <= 1'b0; rstart_q <= 1'b0; area_idx <= 1'b0; cur_dir <= 1'b0;
         r_dir1 <= 1'b0; r_has2 <= 1'b0; r_len1 <= '0;
         r_addr <= '0;   r_iaddr <= '0;  iaddr_left <= '0;
         done <= 1'b0;   nack_err <= 1'b0;
         eng_req <= 1'b0; eng_wdata <= '0; eng_ack <= 1'b0;
         tx_pop <= 1'b0; rx_valid <= 1'b0; rx_data <= '0;
      end else begin
         eng_req  <= 1'b0;
         tx_pop   <= 1'b0;
         rx_valid <= 1'b0;
         done     <= 1'b0;
         if (st == ST_IDLE) begin
            if (go) begin
               nack_err   <= 1'b0;
               r_addr     <= slave_addr;
               r_iaddr    <= iaddr;
               iaddr_left <= iaddr_len;
               cur_dir    <= dec_dir0;
               r_len1     <= dec_len1;
               r_dir1     <= dec_dir1;
               r_has2     <= dec_has2;
               area_idx   <= 1'b0;
               rstart_q   <= 1'b0;
               wait_q     <= 1'b0;
               if (dec_reject) done <= 1'b1;
               else            st   <= ST_ADDR;
            end
         end else if (!wait_q) begin
            eng_req <= 1'b1;
            wait_q  <= 1'b1;
            eng_ack <= 1'b0;
            case (st)
               ST_ADDR: begin
                  op_q      <= rstart_q ? OP_RSTART : OP_START;
                  eng_wdata <= {r_addr, (iaddr_left != '0) ? 1'b0 : cur_dir};
               end
               ST_IADDR: begin
                  op_q      <= OP_WRITE;
                  eng_wdata <= ia_byte;
               end
               ST_DATA: begin
                  if (cur_dir) begin
                     op_q      <= OP_READ;
                     eng_wdata <= '0;
                     eng_ack   <= !(cnt_last && final_area);
                  end else begin
                     op_q      <= OP_WRITE;
                     eng_wdata <= tx_data;
                     tx_pop    <= 1'b1;
                  end
               end
               default: begin
                  op_q      <= OP_STOP;
                  eng_wdata <= '0;
               end
            endcase
         end else if (eng_done) begin
            wait_q <= 1'b0;
            case (st)
               ST_ADDR: begin
                  if (eng_nack) begin
                     nack_err <= 1'b1;
                     st       <= ST_STOP;
                  end else if (iaddr_left != '0) begin
                     st <= ST_IADDR;
                  end else begin
                     st <= ST_DATA;
                  end
               end
               ST_IADDR: begin
                  if (eng_nack) begin
                     nack_err <= 1'b1;
                     st       <= ST_STOP;
                  end else begin
                     iaddr_left <= iaddr_left - IA_W'(1);
                     if (iaddr_left == IA_W'(1)) begin
                        if (cur_dir) begin
                           rstart_q <= 1'b1;
                           st       <= ST_ADDR;
                        end else begin
                           st <= ST_DATA;
                        end
                     end
                  end
               end
               ST_DATA: begin
                  if (wr_refused) begin
                     nack_err <= 1'b1;
                     st       <= ST_STOP;
                  end else begin
                     if (cur_dir) begin
                        rx_valid <= 1'b1;
                        rx_data  <= eng_rdata;
                     end
                     if (cnt_last) begin
                        if (!area_idx && r_has2) begin
                           area_idx <= 1'b1;
                           cur_dir  <= r_dir1;
                           rstart_q <= 1'b1;
                           st       <= ST_ADDR;
                        end else begin
                           st <= ST_STOP;
                        end
                     end
                  end
               end
               default: begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
               end
            endcase
         end
      end
   end

   AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && go && dec_reject) |=> (done && !busy && !eng_req)); // R7
   AST_STOP_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STOP && step_end) |=> (done && !busy)); // R2
   AST_NACK_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      (step_end && eng_nack && (st == ST_ADDR || st == ST_IADDR || (st == ST_DATA && !cur_dir)))
      |=> (st == ST_STOP && nack_err)); // R9
   AST_POP_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |-> (eng_req && op_q == OP_WRITE && st == ST_DATA)); // R10
   AST_NACK_ONLY_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && op_q == OP_READ && !eng_ack) |-> (st == ST_DATA && final_area)); // R8
   AST_BUSY_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && go) |=> $stable(r_addr)); // R11
endmodule

// File: tb/i2c_autostop_seq_test.sv
module i2c_autostop_seq_test;
   localparam int OPS = 1;   // START
   localparam int OPR = 2;   // RSTART
   localparam int OPW = 3;   // WRITE
   localparam int OPD = 4;   // READ
   localparam int OPP = 5;   // STOP
   localparam int LOGN = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_on = 1'b0, mode_off = 1'b0, legacy_rd = 1'b0, go = 1'b0;
   logic [6:0]  slave_addr = '0;
   logic [1:0]  iaddr_len = '0;
   logic [23:0] iaddr = '0;
   logic [31:0] cmd_word = '0;
   logic        busy, done, nack_err, eng_req, eng_ack, tx_pop, rx_valid;
   logic [2:0]  eng_op;
   logic [7:0]  eng_wdata, rx_data, tx_data;
   logic        eng_done = 1'b0, eng_nack = 1'b0;
   logic [7:0]  eng_rdata = '0;

   int checks = 0, failures = 0, cyc = 0;
   int tx_cnt = 0, log_n = 0, rx_n = 0, nack_abs = -1, cd = 0, cur_idx = 0;
   logic [2:0] l_op  [LOGN];
   logic [7:0] l_dat [LOGN];
   logic       l_ack [LOGN];
   logic [7:0] rx_log[LOGN];

   logic [2:0] e_op  [64];
   logic [7:0] e_dat [64];
   logic       e_ack [64];
   int         e_n;
   logic       e_nack;
   int c_mode, c_legacy, c_a0len, c_a0dir, c_a1len, c_a1dir, c_ialen, tx_base;
   logic [23:0] c_iaddr;
   logic [6:0]  c_addr;

   assign tx_data = 8'(32'hA0 + tx_cnt);

   i2c_autostop_seq uut (
      .clk(clk), .rst_n(rst_n), .mode_on(mode_on), .mode_off(mode_off),
      .legacy_rd(legacy_rd), .go(go), .slave_addr(slave_addr),
      .iaddr_len(iaddr_len), .iaddr(iaddr), .cmd_word(cmd_word),
      .busy(busy), .done(done), .nack_err(nack_err), .eng_req(eng_req),
      .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_ack(eng_ack),
      .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata),
      .tx_data(tx_data), .tx_pop(tx_pop), .rx_valid(rx_valid), .rx_data(rx_data)
   );

   always #5 clk = ~clk;

   // bus engine model: logs requests, completes each after a short delay
   always @(posedge clk) begin
      eng_done <= 1'b0;
      if (rst_n) begin
         if (tx_pop) tx_cnt <= tx_cnt + 1;
         if (rx_valid) begin
            rx_log[rx_n] <= rx_data;
            rx_n <= rx_n + 1;
         end
         if (eng_req) begin
            l_op[log_n]  <= eng_op;
            l_dat[log_n] <= eng_wdata;
            l_ack[log_n] <= eng_ack;
            cur_idx <= log_n;
            log_n   <= log_n + 1;
            cd      <= 2;
         end else if (cd != 0) begin
            if (cd == 1) begin
               eng_done  <= 1'b1;
               eng_nack  <= (cur_idx == nack_abs);
               eng_rdata <= 8'(32'h50 + cur_idx);
            end
            cd <= cd - 1;
         end
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         failures = failures + 1;
         $display("FAIL watchdog: run did not end, actual cycles=%0d expected<150000", cyc);
         finish_run();
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push(input int op, input logic [7:0] d, input logic a);
      e_op[e_n] = 3'(op); e_dat[e_n] = d; e_ack[e_n] = a;
      e_n = e_n + 1;
   endtask

   task automatic push_area(input int len, input int dir, input bit fin, inout int w);
      for (int b = 0; b < len; b++) begin
         if (dir != 0) push(OPD, 8'h00, !((b == len - 1) && fin));
         else begin
            push(OPW, 8'(32'hA0 + tx_base + w), 1'b0);
            w = w + 1;
         end
      end
   endtask

   task automatic build_exp();
      int  w = 0;
      int  dir0;
      bit  has2;
      e_n = 0; e_nack = 1'b0;
      dir0 = (c_mode != 0) ? c_a0dir : c_legacy;
      has2 = (c_mode != 0) && (c_a1len != 0);
      if (c_a0len == 0) return;
      push(OPS, {c_addr, (c_ialen != 0) ? 1'b0 : 1'(dir0)}, 1'b0);
      for (int k = c_ialen - 1; k >= 0; k--) push(OPW, c_iaddr[k*8 +: 8], 1'b0);
      if (c_ialen != 0 && dir0 != 0) push(OPR, {c_addr, 1'b1}, 1'b0);
      push_area(c_a0len, dir0, !has2, w);
      if (has2) begin
         push(OPR, {c_addr, 1'(c_a1dir)}, 1'b0);
         push_area(c_a1len, c_a1dir, 1'b1, w);
      end
      push(OPP, 8'h00, 1'b0);
   endtask

   task automatic apply_nack(input int rel, input int base);
      nack_abs = -1;
      if (rel >= 0 && rel < e_n - 1 &&
          (e_op[rel] == 3'(OPS) || e_op[rel] == 3'(OPR) || e_op[rel] == 3'(OPW))) begin
         e_n = rel + 1;
         push(OPP, 8'h00, 1'b0);
         e_nack = 1'b1;
         nack_abs = base + rel;
      end
   endtask

   task automatic set_mode(input logic on_b, input logic off_b);
      @(negedge clk);
      mode_on = on_b; mode_off = off_b;
      @(negedge clk);
      mode_on = 1'b0; mode_off = 1'b0;
   endtask

   task automatic run_case(input string tag, input int nack_rel, input bit busy_go);
      int  lb, rb, t_done, n_act, n_rd, bad;
      bit  got;
      @(negedge clk);
      slave_addr = c_addr; iaddr_len = 2'(c_ialen); iaddr = c_iaddr;
      legacy_rd = 1'(c_legacy);
      cmd_word = '0;
      cmd_word[7:0] = 8'(c_a0len);  cmd_word[8]  = 1'(c_a0dir);
      cmd_word[23:16] = 8'(c_a1len); cmd_word[24] = 1'(c_a1dir);
      lb = log_n; rb = rx_n; tx_base = tx_cnt;
      build_exp();
      apply_nack(nack_rel, lb);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      got = 1'b0; t_done = -1;
      for (int t = 0; t < 3000 && !got; t++) begin
         if (done) begin got = 1'b1; t_done = t; end
         else begin
            if (busy_go && t == 8) begin
               go = 1'b1; cmd_word = ~cmd_word; slave_addr = ~slave_addr;
            end
            @(negedge clk);
            go = 1'b0;
         end
      end
      for (int t = 0; t < (busy_go ? 60 : 6); t++) @(negedge clk);
      chk(got, tag, "done seen", got, 1);
      if (e_n == 0) chk(t_done == 0, tag, "reject done cycle", t_done, 0);
      n_act = log_n - lb;
      chk(n_act == e_n, tag, "engine step count", n_act, e_n);
      bad = -1;
      for (int i = 0; i < e_n && i < n_act; i++) begin
         if (bad < 0 && (l_op[lb+i] != e_op[i] || l_dat[lb+i] != e_dat[i] ||
             (e_op[i] == 3'(OPD) && l_ack[lb+i] != e_ack[i]))) bad = i;
      end
      if (bad >= 0)
         chk(1'b0, tag, "step {op,data,ack}",
             {l_op[lb+bad], l_dat[lb+bad], 3'b0, l_ack[lb+bad]},
             {e_op[bad], e_dat[bad], 3'b0, e_ack[bad]});
      else chk(1'b1, tag, "step list", 0, 0);
      n_rd = 0; bad = -1;
      for (int i = 0; i < e_n; i++) begin
         if (e_op[i] == 3'(OPD)) begin
            if (bad < 0 && rx_log[rb+n_rd] != 8'(32'h50 + lb + i)) bad = n_rd;
            n_rd = n_rd + 1;
         end
      end
      chk(rx_n - rb == n_rd, "R10", {tag, " rx count"}, rx_n - rb, n_rd);
      chk(bad < 0, "R10", {tag, " rx data index"}, bad, -1);
      chk(nack_err == e_nack, tag, "nack_err", nack_err, e_nack);
      nack_abs = -1;
   endtask

   task automatic cfg(input int ia, input int a0l, input int a0d, input int a1l, input int a1d, input int leg);
      c_ialen = ia; c_a0len = a0l; c_a0dir = a0d; c_a1len = a1l; c_a1dir = a1d; c_legacy = leg;
   endtask

   initial begin
      void'($urandom(32'd20150601));
      c_addr = 7'h2A; c_iaddr = 24'h563412; c_mode = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !eng_req && !nack_err, "R10", "reset idle outputs",
          {busy, done, eng_req, nack_err}, 0);
      chk(!tx_pop && !rx_valid, "R10", "reset strobes", {tx_pop, rx_valid}, 0);

      // counted mode off after reset: legacy direction, area 1 ignored (R4)
      cfg(0, 2, 0, 2, 1, 1); run_case("R4 R5 reset-mode legacy read", -1, 1'b0);

      set_mode(1'b1, 1'b0); c_mode = 1;
      cfg(0, 3, 0, 0, 0, 0); run_case("R1 R2 R3 single write", -1, 1'b0);
      cfg(0, 3, 1, 0, 0, 0); run_case("R8 single read", -1, 1'b0);
      cfg(0, 2, 0, 2, 1, 0); run_case("R3 write then read", -1, 1'b0);
      cfg(0, 2, 1, 2, 1, 0); run_case("R8 read then read", -1, 1'b0);
      cfg(2, 3, 1, 0, 0, 0); run_case("R6 iaddr read", -1, 1'b0);
      cfg(3, 2, 0, 0, 0, 0); run_case("R6 iaddr write", -1, 1'b0);
      cfg(1, 1, 0, 1, 1, 0); run_case("R6 R3 iaddr write then read", -1, 1'b0);
      cfg(0, 0, 0, 2, 1, 0); run_case("R7 zero first area", -1, 1'b0);
      cfg(0, 4, 0, 0, 0, 0); run_case("R9 nack on write data", 2, 1'b0);
      cfg(0, 3, 1, 2, 0, 0); run_case("R9 nack on address", 0, 1'b0);
      cfg(2, 2, 1, 0, 0, 0); run_case("R9 nack on iaddr byte", 1, 1'b0);
      cfg(0, 2, 0, 0, 0, 1); run_case("R4 legacy_rd ignored in counted mode", -1, 1'b0);
      cfg(0, 3, 0, 1, 1, 0); run_case("R11 go while busy", -1, 1'b0);
      cfg(0, 3, 0, 1, 1, 0); run_case("R11 go while busy", -1, 1'b1);

      set_mode(1'b1, 1'b1); c_mode = 0;
      cfg(0, 2, 1, 2, 1, 0); run_case("R5 off wins clash", -1, 1'b0);
      cfg(1, 1, 0, 3, 0, 1); run_case("R4 legacy read with iaddr", -1, 1'b0);
      set_mode(1'b1, 1'b0); c_mode = 1;

      for (int r = 0; r < 40; r++) begin
         int nrel;
         cfg(int'($urandom_range(0, 3)), int'($urandom_range(0, 4)), int'($urandom_range(0, 1)),
             int'($urandom_range(0, 3)), int'($urandom_range(0, 1)), int'($urandom_range(0, 1)));
         c_addr  = 7'($urandom);
         c_iaddr = 24'($urandom);
         if (r == 20) begin set_mode(1'b0, 1'b1); c_mode = 0; end
         if (r == 30) begin set_mode(1'b1, 1'b0); c_mode = 1; end
         nrel = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 12)) : -1;
         run_case("R2 R9 random", nrel, 1'b0);
      end
      finish_run();
   end
endmodule